// File: doc/BRIEF.md
# Slow Serial Clock Divider with Phase Strobe

This block turns a fast system clock (50 MHz in the intended use) into a slow serial clock of about 400 kHz. An 8-bit count runs on every system edge. When it reaches a programmable half-period value, the count returns to zero and the slow clock flips. The slow clock is only ever an output. No register anywhere is clocked by it.

Work that belongs to the slow clock is paced by a one-cycle enable pulse in the system domain instead. The pulse fires at a fixed count (0x1F) inside each low half of the slow clock. Each pulse advances an 8-bit sequencing state. Reset loads that state from an input, which sets where the sequence starts.

Because 50 MHz / 400 kHz gives 62.5 system cycles per half-period, the compare value has to be 61 or 62. The resulting frequency error is accepted.

Top module: `serclk_sequencer`

## Requirements
- R1: While `rst_n` is low, at each clock edge, `sclk_out` goes low, `step_pulse` is low, and `state_q` loads `start_state`. This holds whatever the previous level of `sclk_out` was.
- R2: After reset is released, `sclk_out` stays low for exactly `half_cmp`+1 system cycles. It then alternates between high and low, each level lasting `half_cmp`+1 cycles.
- R3: `step_pulse` is high only while `sclk_out` is low, and never for two system cycles in a row.
- R4: When `half_cmp` > 0x1F, `step_pulse` is high in exactly one cycle of each low half of `sclk_out`. That cycle is the 32nd cycle of the low half, where the first low cycle is numbered 1 (internal count 0x1F).
- R5: When `half_cmp` = 0x1F, the half-period match wins over the pulse point in the same cycle, so `step_pulse` never goes high.
- R6: When `half_cmp` < 0x1F, the count never reaches the pulse point, so `step_pulse` never goes high.
- R7: `state_q` becomes its previous value plus one in the cycle after each `step_pulse`. In every other cycle it holds its value.
- R8: `state_q` wraps from 0xFF to 0x00 on a pulse.
- R9: `half_cmp` = 61 gives a slow-clock period of 124 system cycles (about 403.2 kHz from 50 MHz). `half_cmp` = 62 gives a period of 126 system cycles (about 396.8 kHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_cmp | input | 8 | Half-period compare value (half-period = value + 1 cycles) |
| start_state | input | 8 | State loaded into `state_q` during reset |
| sclk_out | output | 1 | Divided slow serial clock |
| step_pulse | output | 1 | One-cycle enable at count 0x1F of each low half |
| state_q | output | 8 | Current sequencing state |

## Verification
The bench builds the block with its default parameters: an 8-bit count, an 8-bit state and the pulse point at 0x1F. With an 8-bit count, every compare value from 0 to 255 can be reached. That lets directed runs cover the values just below, at and just above the pulse point, which exercise the match-priority case. It also covers 61, 62 and the longest half-period, 255. With an 8-bit state, a few dozen pulses from a start near 0xFF are enough to reach the wrap. Random segments then draw the compare value and the start state from their full ranges.

// File: rtl/serclk_pkg.sv
// Package: shared defaults for the slow serial clock divider.
// Assumes: nothing beyond IEEE 1800-2017 parameter semantics.
package serclk_pkg;
    localparam int unsigned DEF_CNT_W   = 8;
    localparam int unsigned DEF_STATE_W = 8;
    localparam int unsigned DEF_PULSE_AT = 31;
endpackage

// File: rtl/serclk_halfcount.sv
// Module: half-period counter and slow clock toggle.
// What it does: counts system cycles. When the count equals the compare
// value, it clears the count and flips the slow clock.
// Assumes: the compare value is held steady while running. If the value is
// lowered below the current count, the count runs on and wraps through zero.
module serclk_halfcount #(
    parameter int unsigned CNT_W = serclk_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             match,
    output logic             sclk_q
);
    // Purpose: flag the last cycle of the current half-period.
    always_comb begin
        match = (cnt_q == cmp_val);
    end

    // Purpose: advance or clear the count, and flip the slow clock on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (match) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/serclk_phase_strobe.sv
// Module: phase strobe decoder.
// What it does: raises a one-cycle enable when the count sits at the fixed
// pulse point while the slow clock is low. A half-period match in the same
// cycle suppresses the enable.
// Assumes: the inputs come straight from registers, so the output has no
// glitch on a cycle boundary.
module serclk_phase_strobe #(
    parameter int unsigned CNT_W    = serclk_pkg::DEF_CNT_W,
    parameter int unsigned PULSE_AT = serclk_pkg::DEF_PULSE_AT
) (
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             match,
    input  logic             sclk_q,
    output logic             strobe
);
    localparam logic [CNT_W-1:0] PULSE_CNT = CNT_W'(PULSE_AT);

    // Purpose: decode the pulse point; the half-period match takes priority.
    always_comb begin
        strobe = !match && !sclk_q && (cnt_q == PULSE_CNT);
    end
endmodule

// File: rtl/serclk_step_state.sv
// Module: sequencing state register.
// What it does: loads the start state during reset, then adds one on each
// strobe, wrapping at the top of its range.
// Assumes: the strobe is a single-cycle pulse in the same clock domain.
module serclk_step_state #(
    parameter int unsigned STATE_W = serclk_pkg::DEF_STATE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STATE_W-1:0] start_val,
    input  logic               step,
    output logic [STATE_W-1:0] state_q
);
    // Purpose: load on reset, step on a strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= start_val;
        end else if (step) begin
            state_q <= state_q + 1'b1;
        end
    end
endmodule

// File: rtl/serclk_sequencer.sv
// Module: top of the slow serial clock divider with phase strobe.
// What it does: produces the divided clock as a plain output, and a strobe
// that paces a state register in the system domain.
// Assumes: synchronous active-low reset; half_cmp > PULSE_AT if strobes are
// wanted.
module serclk_sequencer #(
    parameter int unsigned CNT_W    = serclk_pkg::DEF_CNT_W,
    parameter int unsigned STATE_W  = serclk_pkg::DEF_STATE_W,
    parameter int unsigned PULSE_AT = serclk_pkg::DEF_PULSE_AT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   half_cmp,
    input  logic [STATE_W-1:0] start_state,
    output logic               sclk_out,
    output logic               step_pulse,
    output logic [STATE_W-1:0] state_q
);
    logic [CNT_W-1:0] cnt_w;
    logic             match_w;

    serclk_halfcount #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_val (half_cmp),
        .cnt_q   (cnt_w),
        .match   (match_w),
        .sclk_q  (sclk_out)
    );

    serclk_phase_strobe #(.CNT_W(CNT_W), .PULSE_AT(PULSE_AT)) u_strobe (
        .cnt_q  (cnt_w),
        .match  (match_w),
        .sclk_q (sclk_out),
        .strobe (step_pulse)
    );

    serclk_step_state #(.STATE_W(STATE_W)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_val (start_state),
        .step      (step_pulse),
        .state_q   (state_q)
    );
endmodule

// File: rtl/serclk_sequencer_chk.sv
// Module: property checker for serclk_sequencer, attached through bind.
// Assumes: half_cmp is held steady between resets.
module serclk_sequencer_chk #(
    parameter int unsigned CNT_W    = serclk_pkg::DEF_CNT_W,
    parameter int unsigned STATE_W  = serclk_pkg::DEF_STATE_W,
    parameter int unsigned PULSE_AT = serclk_pkg::DEF_PULSE_AT
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CNT_W-1:0]   half_cmp,
    input logic [STATE_W-1:0] start_state,
    input logic               sclk_out,
    input logic               step_pulse,
    input logic [STATE_W-1:0] state_q
);
    localparam int unsigned RUN_W = CNT_W + 2;

    logic             sclk_prev;
    logic [RUN_W-1:0] run_len;

    // Purpose: measure how long the slow clock has held its level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            run_len   <= '0;
        end else begin
            sclk_prev <= sclk_out;
            run_len   <= (sclk_out != sclk_prev) ? RUN_W'(1) : run_len + 1'b1;
        end
    end

    assert_reset_load_R1: assert property (@(posedge clk)
        !rst_n |=> (!sclk_out && !step_pulse && state_q == $past(start_state)));

    assert_half_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_out != sclk_prev) |-> (run_len == RUN_W'(half_cmp) + RUN_W'(1)));

    assert_pulse_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |-> !sclk_out);

    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |=> !step_pulse);

    assert_no_pulse_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (half_cmp <= CNT_W'(PULSE_AT)) |-> !step_pulse);

    assert_state_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |=> (state_q == $past(state_q) + 1'b1));

    assert_state_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !step_pulse |=> $stable(state_q));
endmodule

bind serclk_sequencer serclk_sequencer_chk #(
    .CNT_W(CNT_W), .STATE_W(STATE_W), .PULSE_AT(PULSE_AT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .half_cmp    (half_cmp),
    .start_state (start_state),
    .sclk_out    (sclk_out),
    .step_pulse  (step_pulse),
    .state_q     (state_q)
);

// File: tb/serclk_sequencer_tb.sv
// Bench: directed and seeded random segments. Each segment resets the block
// with a new compare value and start state, then compares every cycle
// against expectations computed from the requirements.
module serclk_sequencer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] half_cmp = 8'd61;
    logic [7:0] start_state = 8'd0;
    logic       sclk_out;
    logic       step_pulse;
    logic [7:0] state_q;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    serclk_sequencer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .half_cmp    (half_cmp),
        .start_state (start_state),
        .sclk_out    (sclk_out),
        .step_pulse  (step_pulse),
        .state_q     (state_q)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected slow clock level s samples after reset release.
    function automatic bit exp_sclk(input int s, input int n);
        return ((s / (n + 1)) % 2) == 1;
    endfunction

    // Expected pulse: low half, 32nd cycle, and only when cmp > 0x1F.
    function automatic bit exp_pulse(input int s, input int n);
        return !exp_sclk(s, n) && (s % (n + 1)) == 31 && n > 31;
    endfunction

    task automatic segment(input int n, input int start, input int periods);
        int  st;
        bit  prev_pulse;
        half_cmp    = 8'(n);
        start_state = 8'(start);
        rst_n       = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(!sclk_out, "R1 sclk", int'(sclk_out), 0);
        check(!step_pulse, "R1 pulse", int'(step_pulse), 0);
        check(state_q == 8'(start), "R1 state", int'(state_q), start);
        rst_n      = 1'b1;
        st         = start;
        prev_pulse = 1'b0;
        for (int s = 0; s < periods * 2 * (n + 1); s++) begin
            // Sample taken s system cycles after reset release.
            if (s > 0) @(negedge clk);
            if (n == 61 || n == 62)
                check(sclk_out == exp_sclk(s, n), "R9 sclk", int'(sclk_out), int'(exp_sclk(s, n)));
            else
                check(sclk_out == exp_sclk(s, n), "R2 sclk", int'(sclk_out), int'(exp_sclk(s, n)));
            if (n == 31)
                check(step_pulse == 1'b0, "R5 pulse", int'(step_pulse), 0);
            else if (n < 31)
                check(step_pulse == 1'b0, "R6 pulse", int'(step_pulse), 0);
            else
                check(step_pulse == exp_pulse(s, n), "R4 pulse", int'(step_pulse), int'(exp_pulse(s, n)));
            if (step_pulse) begin
                check(!sclk_out, "R3 low", int'(sclk_out), 0);
                check(!prev_pulse, "R3 single", int'(prev_pulse), 0);
            end
            check(state_q == 8'(st), "R7 state", int'(state_q), st & 255);
            if (prev_pulse && (st & 255) == 0)
                check(state_q == 8'd0, "R8 wrap", int'(state_q), 0);
            prev_pulse = step_pulse;
            if (exp_pulse(s, n)) st = (st + 1) & 255;
        end
    endtask

    initial begin
        void'($urandom(32'd1357));
        segment(61, 8'h10, 3);
        segment(62, 8'h20, 3);
        segment(31, 8'h33, 3);
        segment(16, 8'h44, 3);
        segment(0, 8'h55, 4);
        segment(32, 8'hF8, 12);
        segment(255, 8'hFE, 3);
        for (int k = 0; k < 6; k++)
            segment(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)), 3);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule